// File: doc/BRIEF.md
# Shared-Address I/O Port Block

This block sits on a 16-bit I/O address space and answers for a group of addresses whose upper byte is 0xEF. At group offset 0x00 it offers two ports at one address. One is a byte output register: a write to it is latched, and the value stays on its output pins after the short bus cycle has ended, so it can drive loads such as indicator lamps. The other is a byte input port: it drives external pin values onto the shared read bus, but only while a read to that address is in progress. The read strobe and the write strobe alone tell the two ports apart.

At offsets 0x02/0x03 an optional word output register sits. It has two byte lanes. The lane chosen by address bit 0 low takes the low byte, and the lane chosen by an active-low high-byte enable takes the high byte, so one aligned write can fill both lanes or a single byte write can fill one. The tri-state bus is modelled as an output-enable together with a data value that is forced to zero while the enable is low. The read sources of a system can then be OR-combined and checked for contention.

Top module: `io_port_block`

## Requirements
- R1: The group is selected only when address bits 15..8 equal 0xEF. Address bits above bit 15 play no part in decoding.
- R2: On a rising clock edge with wr_n low and address bits 15..0 equal to 0xEF00, the byte output register takes wdata[7:0]. The new value shows on led_out from that edge onward.
- R3: Without a matching write, led_out and word_out keep their values. Reads, writes to other addresses and writes to offset 0x01 leave them unchanged.
- R4: While rd_n is low and address bits 15..0 equal 0xEF00, bus_oe is 1 and bus_rdata follows pins_in with no clock delay.
- R5: At all other times bus_oe is 0 and bus_rdata is 0x00. This includes reads of the word port offsets and reads outside the group.
- R6: On a rising edge with wr_n low, address bits 15..1 selecting offset 0x02/0x03 and address bit 0 low, word_out[7:0] takes wdata[7:0].
- R7: On a rising edge with wr_n low, the same word-port decode and bhe_n low, word_out[15:8] takes wdata[15:8]. When neither qualifier is active, the write changes nothing.
- R8: While rst_n is low, led_out is 0x00 and word_out is 0x0000, asynchronously to the clock.
- R9: A read and a write to 0xEF00 in the same cycle both take effect. The read returns pins_in and the write latches wdata[7:0].

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| io_addr | input | 20 | I/O address; only bits 15..0 decoded |
| wdata | input | 16 | Write data, low lane bits 7..0 |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bhe_n | input | 1 | Active-low high-byte enable |
| pins_in | input | 8 | External input pins for the input port |
| bus_rdata | output | 8 | Read data toward the shared bus, 0 when not enabled |
| bus_oe | output | 1 | Read-bus drive enable |
| led_out | output | 8 | Latched byte output port |
| word_out | output | 16 | Latched word output port |

## Verification
The input port and the byte output register share 0xEF00, so a read and a write to that address can fall in the same cycle. The bench provokes this by driving rd_n and wr_n low together with differing pins_in and wdata. It then judges both results: bus_rdata must equal the pins in that same cycle, and led_out must show the written byte after the edge. The word port's two lane qualifiers can also coincide, and this is judged by toggling address bit 0 and bhe_n independently across writes.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int unsigned DEC_W      = 16;      // decoded address bits
  localparam logic [7:0]  GROUP_TAG  = 8'hEF;   // upper address byte of the group
  localparam logic [7:0]  BYTE_OFS   = 8'h00;   // shared input/output byte port
  localparam logic [6:0]  WORD_SLOT  = 7'h01;   // offsets 0x02/0x03 word port
  localparam int unsigned LANE_W     = 8;

  typedef struct packed {
    logic byte_rd;
    logic byte_wr;
    logic word_lo_wr;
    logic word_hi_wr;
  } port_sel_t;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bhe_n,
  output port_sel_t         sel
);
  logic [DEC_W-1:0] low_addr;
  logic             grp_hit;
  logic             byte_hit;
  logic             word_hit;

  // only the decoded span is looked at; higher bits are dropped
  assign low_addr = addr[DEC_W-1:0];
  assign grp_hit  = (low_addr[15:8] == GROUP_TAG);
  assign byte_hit = grp_hit && (low_addr[7:0] == BYTE_OFS);
  assign word_hit = grp_hit && (low_addr[7:1] == WORD_SLOT);

  always_comb begin
    sel            = '0;
    sel.byte_rd    = byte_hit && !rd_n;
    sel.byte_wr    = byte_hit && !wr_n;
    sel.word_lo_wr = word_hit && !wr_n && !low_addr[0];
    sel.word_hi_wr = word_hit && !wr_n && !bhe_n;
  end
endmodule

// File: rtl/io_lane_reg.sv
module io_lane_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R3
  AST_LANE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d))); // R2
endmodule

// File: rtl/io_in_gate.sv
module io_in_gate #(
  parameter int unsigned W = 8
) (
  input  logic         rd_sel,
  input  logic [W-1:0] pins,
  output logic         oe,
  output logic [W-1:0] rdata
);
  always_comb begin
    oe    = rd_sel;
    rdata = '0;
    if (rd_sel) rdata = pins;
  end
endmodule

// File: rtl/io_port_block.sv
module io_port_block
  import io_port_pkg::*;
#(
  parameter int unsigned ADDR_W       = 20,
  parameter bit          WORD_PORT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [15:0]       wdata,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bhe_n,
  input  logic [7:0]        pins_in,
  output logic [7:0]        bus_rdata,
  output logic              bus_oe,
  output logic [7:0]        led_out,
  output logic [15:0]       word_out
);
  localparam int unsigned LANES = 16 / LANE_W;

  port_sel_t sel;

  io_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (io_addr),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .bhe_n (bhe_n),
    .sel   (sel)
  );

  io_in_gate #(.W(LANE_W)) u_in (
    .rd_sel (sel.byte_rd),
    .pins   (pins_in),
    .oe     (bus_oe),
    .rdata  (bus_rdata)
  );

  io_lane_reg #(.W(LANE_W)) u_led (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sel.byte_wr),
    .d     (wdata[LANE_W-1:0]),
    .q     (led_out)
  );

  generate
    if (WORD_PORT_EN) begin : g_word
      logic [LANES-1:0] lane_en;
      assign lane_en[0] = sel.word_lo_wr;
      assign lane_en[1] = sel.word_hi_wr;
      for (genvar g = 0; g < LANES; g++) begin : g_lane
        io_lane_reg #(.W(LANE_W)) u_lane (
          .clk   (clk),
          .rst_n (rst_n),
          .en    (lane_en[g]),
          .d     (wdata[g*LANE_W +: LANE_W]),
          .q     (word_out[g*LANE_W +: LANE_W])
        );
      end
    end else begin : g_noword
      assign word_out = '0;
    end
  endgenerate

  AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!rd_n && io_addr[15:0] == {GROUP_TAG, BYTE_OFS})); // R4
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_rdata == 8'h00)); // R5
  AST_HIGH_LANE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bhe_n || wr_n) |=> $stable(word_out[15:8])); // R7
  AST_LED_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(led_out)); // R3
endmodule

// File: tb/tb_io_port_block.sv
module tb_io_port_block;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] io_addr;
  logic [15:0] wdata;
  logic        rd_n, wr_n, bhe_n;
  logic [7:0]  pins_in;
  logic [7:0]  bus_rdata;
  logic        bus_oe;
  logic [7:0]  led_out;
  logic [15:0] word_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  io_port_block dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wdata(wdata),
    .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .pins_in(pins_in),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe), .led_out(led_out), .word_out(word_out)
  );

  // {req, addr, wdata, rd_n, wr_n, bhe_n, pins, exp_oe, exp_rdata, exp_led, exp_word}
  localparam int NV = 13;
  localparam logic [83:0] VEC [NV] = '{
    {4'd2, 20'h0EF00, 16'h00A5, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'hA5, 16'h0000}, // R2
    {4'd1, 20'h0EE00, 16'h003C, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'hA5, 16'h0000}, // R1
    {4'd1, 20'h5EF00, 16'h0011, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h11, 16'h0000}, // R1
    {4'd4, 20'h0EF00, 16'h0000, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A, 8'h11, 16'h0000}, // R4
    {4'd5, 20'h0EF02, 16'h0000, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h11, 16'h0000}, // R5
    {4'd5, 20'h0EE00, 16'h0000, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h11, 16'h0000}, // R5
    {4'd7, 20'h0EF02, 16'hBEEF, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h11, 16'hBEEF}, // R7
    {4'd6, 20'h0EF02, 16'h1234, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h11, 16'hBE34}, // R6
    {4'd7, 20'h0EF03, 16'h5678, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h11, 16'h5634}, // R7
    {4'd7, 20'h0EF03, 16'h9999, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h11, 16'h5634}, // R7
    {4'd9, 20'h0EF00, 16'h0077, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b1, 8'hC3, 8'h77, 16'h5634}, // R9
    {4'd3, 20'h0EF00, 16'h00FF, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 8'h77, 16'h5634}, // R3
    {4'd3, 20'h0EF01, 16'h0022, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h77, 16'h5634}  // R3
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    io_addr = 20'h0; wdata = 16'h0; rd_n = 1'b1; wr_n = 1'b1; bhe_n = 1'b1; pins_in = 8'h0;
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_bus();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(led_out == 8'h00, 8, "led reset", {8'h0, led_out}, 16'h0000);
    chk(word_out == 16'h0000, 8, "word reset", word_out, 16'h0000);
    chk(bus_oe == 1'b0, 5, "oe idle", {15'h0, bus_oe}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      int          rq;
      v = VEC[i];
      rq = int'(v[83:80]);
      @(negedge clk);
      io_addr = v[79:60]; wdata = v[59:44];
      rd_n = v[43]; wr_n = v[42]; bhe_n = v[41]; pins_in = v[40:33];
      #1;
      chk(bus_oe == v[32], rq, "bus_oe", {15'h0, bus_oe}, {15'h0, v[32]});
      chk(bus_rdata == v[31:24], rq, "bus_rdata", {8'h0, bus_rdata}, {8'h0, v[31:24]});
      @(posedge clk);
      #2;
      chk(led_out == v[23:16], rq, "led_out", {8'h0, led_out}, {8'h0, v[23:16]});
      chk(word_out == v[15:0], rq, "word_out", word_out, v[15:0]);
    end

    // R4: read data follows pins with no clock delay
    @(negedge clk);
    io_addr = 20'h0EF00; rd_n = 1'b0; wr_n = 1'b1; pins_in = 8'h81;
    #1;
    chk(bus_rdata == 8'h81, 4, "pins follow a", {8'h0, bus_rdata}, 16'h0081);
    pins_in = 8'h3E;
    #1;
    chk(bus_rdata == 8'h3E, 4, "pins follow b", {8'h0, bus_rdata}, 16'h003E);
    // R5: top of group range is not the byte port
    io_addr = 20'h0EFFF;
    #1;
    chk(bus_oe == 1'b0, 5, "oe at EFFF", {15'h0, bus_oe}, 16'h0000);

    // R8: asynchronous reset mid-run
    @(negedge clk);
    idle_bus();
    #1;
    rst_n = 1'b0;
    #1;
    chk(led_out == 8'h00, 8, "led async reset", {8'h0, led_out}, 16'h0000);
    chk(word_out == 16'h0000, 8, "word async reset", word_out, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule